// File: doc/BRIEF.md
# Wide-to-Narrow Bus Width Adapter

This block joins a 32-bit memory-mapped master to a 16-bit memory-mapped slave. Each master read or write is accepted once, carried out as one or more slave transfers, and answered by a single low cycle on the master wait request. Read data from the slave is assembled into the master's read-data register.

A static parameter picks the addressing style. In split mode every master word becomes two halfword transfers. The low halfword goes first and the high halfword second. Each half carries its own pair of byte enables, and the second half is issued even when both of its enables are off. In truncating mode one slave transfer is made at the word index. The upper 16 write bits are dropped and the upper 16 read bits come back as zero.

Both sides follow a wait-request handshake with zero-latency reads. The master holds its request until it sees its wait request low. The slave delivers read data in the cycle in which its own wait request is low.

Top module: `bus_width_adapter`

## Requirements
- R1: After a synchronous reset, both slave strobes are low and the master wait request is high.
- R2: In split mode, each master access (byte address A, word aligned) makes exactly two slave transfers. The first goes to halfword address A/2 and the second to A/2+1.
- R3: In split mode, the first slave transfer carries master byte enables [1:0] and the second carries [3:2]. The second transfer is still issued when those two enables are both 0.
- R4: In split mode, a write sends write data bits [15:0] in the first transfer and bits [31:16] in the second.
- R5: In split mode, read data returned to the master is {second halfword, first halfword}.
- R6: In truncating mode, each master access makes exactly one slave transfer. Its address is A/4 and its byte enables are master enables [1:0].
- R7: In truncating mode, a write sends only write data bits [15:0], and read data returns with bits [31:16] equal to zero.
- R8: The master wait request goes low for exactly one cycle, and only after the last slave transfer of the access has completed. Read data is valid in that cycle. With slave stall count s, it is first seen low 2s+3 cycles after the request in split mode and s+2 cycles after it in truncating mode.
- R9: While the slave holds its wait request high, the adapter keeps its strobe, address, byte enables and write data unchanged.
- R10: A reset in the middle of an access drops both slave strobes and returns the adapter to idle. The next access then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_address | input | AW | Master byte address, word aligned |
| m_byteenable | input | 4 | Master byte-lane enables |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_writedata | input | 32 | Master write data |
| m_readdata | output | 32 | Assembled read data |
| m_waitrequest | output | 1 | Low for one cycle when the access ends |
| s_address | output | AW-1 | Slave halfword address |
| s_byteenable | output | 2 | Slave byte-lane enables |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_writedata | output | 16 | Slave write data |
| s_readdata | input | 16 | Slave read data, valid when its wait request is low |
| s_waitrequest | input | 1 | Slave stall |

## Verification
The hardest situation to reach is a reset that arrives while a slave transfer is stalled partway through a split access. The stall is the only thing that keeps the adapter inside a transfer long enough for reset to land there. The bench's slave model holds its wait request for a programmable number of cycles per transfer, and the bench starts a read under a long stall, raises reset three cycles in, and then checks that the strobes have dropped and that a following access still returns correct data. The empty-enable second half is reached by sweeping every 4-bit enable pattern over the address space, so that both "only low lanes" and "no lanes" writes occur.

// File: rtl/wadp_pkg.sv
package wadp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_ACK  = 2'd3
  } wadp_state_e;
endpackage

// File: rtl/wadp_lane_route.sv
// Selects the slave address, lane enables and write halfword for the current phase.
module wadp_lane_route #(
  parameter int  AW    = 8,
  parameter int  MDW   = 32,
  parameter bit  SPLIT = 1'b1,
  localparam int SDW   = MDW / 2,
  localparam int MBE   = MDW / 8,
  localparam int SBE   = SDW / 8,
  localparam int WOB   = $clog2(MBE),
  localparam int SAW   = AW - $clog2(SBE)
) (
  input  logic [AW-WOB-1:0] widx,
  input  logic [MBE-1:0]    be,
  input  logic [MDW-1:0]    wdata,
  input  logic              sel_hi,
  output logic [SAW-1:0]    s_addr,
  output logic [SBE-1:0]    s_be,
  output logic [SDW-1:0]    s_wdata
);
  // Lane and data selection is shared; in truncating mode sel_hi never rises.
  assign s_be    = sel_hi ? be[MBE-1:SBE]    : be[SBE-1:0];
  assign s_wdata = sel_hi ? wdata[MDW-1:SDW] : wdata[SDW-1:0];

  generate
    if (SPLIT) begin : g_split_addr
      assign s_addr = {widx, sel_hi};
    end else begin : g_trunc_addr
      assign s_addr = SAW'(widx);
    end
  endgenerate
endmodule

// File: rtl/wadp_rd_assemble.sv
// Builds the master read word from one or two slave halfwords.
module wadp_rd_assemble #(
  parameter int  MDW = 32,
  localparam int SDW = MDW / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap_lo,
  input  logic           cap_hi,
  input  logic [SDW-1:0] s_rdata,
  output logic [MDW-1:0] rdata
);
  // The low half is held here until the high half returns; in truncating
  // mode cap_hi never rises, so the upper half stays at its reset zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      if (cap_lo) rdata[SDW-1:0]   <= s_rdata;
      if (cap_hi) rdata[MDW-1:SDW] <= s_rdata;
    end
  end

  assert_lanes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(cap_lo && cap_hi));
endmodule

// File: rtl/wadp_seq.sv
// Transfer sequencer: accepts one master access and walks its slave phases.
module wadp_seq #(
  parameter bit SPLIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_rd,
  input  logic req_wr,
  input  logic s_wait,
  output logic take,
  output logic step_hi,
  output logic lo_done,
  output logic hi_done,
  output logic s_rd,
  output logic s_wr,
  output logic ack
);
  import wadp_pkg::*;

  wadp_state_e state;

  assign take    = (state == ST_IDLE) && (req_rd || req_wr);
  assign lo_done = (state == ST_LO) && !s_wait;
  assign step_hi = lo_done && SPLIT;
  assign hi_done = (state == ST_HI) && !s_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      s_rd  <= 1'b0;
      s_wr  <= 1'b0;
      ack   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            s_wr  <= req_wr;
            s_rd  <= req_rd && !req_wr;
            state <= ST_LO;
          end
        end
        ST_LO: begin
          if (!s_wait) begin
            if (SPLIT) begin
              state <= ST_HI;
            end else begin
              s_rd  <= 1'b0;
              s_wr  <= 1'b0;
              ack   <= 1'b1;
              state <= ST_ACK;
            end
          end
        end
        ST_HI: begin
          if (!s_wait) begin
            s_rd  <= 1'b0;
            s_wr  <= 1'b0;
            ack   <= 1'b1;
            state <= ST_ACK;
          end
        end
        default: begin
          ack   <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_ack_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(s_rd && s_wr));
  assert_idle_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    ack |-> !s_rd && !s_wr);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !s_rd && !s_wr && !ack);
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
  parameter int  AW    = 8,
  parameter int  MDW   = 32,
  parameter bit  SPLIT = 1'b1,
  localparam int SDW   = MDW / 2,
  localparam int MBE   = MDW / 8,
  localparam int SBE   = SDW / 8,
  localparam int WOB   = $clog2(MBE),
  localparam int SAW   = AW - $clog2(SBE),
  localparam int NCYC  = SPLIT ? 2 : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  m_address,
  input  logic [MBE-1:0] m_byteenable,
  input  logic           m_read,
  input  logic           m_write,
  input  logic [MDW-1:0] m_writedata,
  output logic [MDW-1:0] m_readdata,
  output logic           m_waitrequest,
  output logic [SAW-1:0] s_address,
  output logic [SBE-1:0] s_byteenable,
  output logic           s_read,
  output logic           s_write,
  output logic [SDW-1:0] s_writedata,
  input  logic [SDW-1:0] s_readdata,
  input  logic           s_waitrequest
);
  logic take, step_hi, lo_done, hi_done, ack;

  logic [AW-WOB-1:0] h_widx;
  logic [MBE-1:0]    h_be;
  logic [MDW-1:0]    h_wdata;

  logic [AW-WOB-1:0] r_widx;
  logic [MBE-1:0]    r_be;
  logic [MDW-1:0]    r_wdata;
  logic [SAW-1:0]    n_addr;
  logic [SBE-1:0]    n_be;
  logic [SDW-1:0]    n_wdata;

  wadp_seq #(.SPLIT(SPLIT)) seq_i (
    .clk(clk), .rst(rst),
    .req_rd(m_read), .req_wr(m_write), .s_wait(s_waitrequest),
    .take(take), .step_hi(step_hi), .lo_done(lo_done), .hi_done(hi_done),
    .s_rd(s_read), .s_wr(s_write), .ack(ack)
  );

  // Request capture: the first phase routes straight from the master inputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_widx  <= '0;
      h_be    <= '0;
      h_wdata <= '0;
    end else if (take) begin
      h_widx  <= m_address[AW-1:WOB];
      h_be    <= m_byteenable;
      h_wdata <= m_writedata;
    end
  end

  assign r_widx  = take ? m_address[AW-1:WOB] : h_widx;
  assign r_be    = take ? m_byteenable        : h_be;
  assign r_wdata = take ? m_writedata         : h_wdata;

  wadp_lane_route #(.AW(AW), .MDW(MDW), .SPLIT(SPLIT)) route_i (
    .widx(r_widx), .be(r_be), .wdata(r_wdata), .sel_hi(step_hi),
    .s_addr(n_addr), .s_be(n_be), .s_wdata(n_wdata)
  );

  // Registered slave address and data, reloaded only at phase starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_address    <= '0;
      s_byteenable <= '0;
      s_writedata  <= '0;
    end else if (take || step_hi) begin
      s_address    <= n_addr;
      s_byteenable <= n_be;
      s_writedata  <= n_wdata;
    end
  end

  wadp_rd_assemble #(.MDW(MDW)) rd_i (
    .clk(clk), .rst(rst),
    .cap_lo(lo_done && s_read), .cap_hi(hi_done && s_read),
    .s_rdata(s_readdata), .rdata(m_readdata)
  );

  assign m_waitrequest = !ack;

  // Checker: completed slave transfers per master access.
  logic [1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst || take) chk_cnt <= '0;
    else if ((s_read || s_write) && !s_waitrequest) chk_cnt <= chk_cnt + 2'd1;
  end

  // R2 and R6: two transfers when splitting, one when truncating.
  assert_xfer_count_R2: assert property (@(posedge clk) disable iff (rst)
    !m_waitrequest |-> chk_cnt == 2'(NCYC));
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (m_read || m_write) |-> m_address[WOB-1:0] == '0);
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (s_read || s_write) && s_waitrequest |=>
      (s_read || s_write) && $stable(s_address) && $stable(s_byteenable)
      && $stable(s_writedata) && $stable(s_read));
  assert_wait_high_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> m_waitrequest);
endmodule

// File: tb/bus_width_adapter_tb_top.sv
module wadp_tb_slave #(
  parameter int SAW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     stall_len,
  input  logic [SAW-1:0] addr,
  input  logic [1:0]     be,
  input  logic           rd,
  input  logic           wr,
  input  logic [15:0]    wdata,
  output logic [15:0]    rdata,
  output logic           waitreq
);
  logic [15:0] mem [2**SAW];
  logic [3:0]  cnt;
  int          done_cnt;
  int          unstable;
  logic [SAW-1:0] log_a  [4];
  logic [1:0]     log_be [4];
  logic [15:0]    log_wd [4];
  logic           p_stall;
  logic [SAW-1:0] p_a;
  logic [1:0]     p_be;
  logic [15:0]    p_wd;

  assign waitreq = (rd || wr) && (cnt < stall_len);
  assign rdata   = mem[addr];

  always_ff @(posedge clk) begin
    if (wr && !waitreq) begin
      if (be[0]) mem[addr][7:0]  <= wdata[7:0];
      if (be[1]) mem[addr][15:8] <= wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      done_cnt <= 0;
      unstable <= 0;
      p_stall  <= 1'b0;
    end else begin
      if ((rd || wr) && waitreq) cnt <= cnt + 4'd1;
      else cnt <= '0;
      if ((rd || wr) && !waitreq) begin
        log_a[done_cnt % 4]  <= addr;
        log_be[done_cnt % 4] <= be;
        log_wd[done_cnt % 4] <= wdata;
        done_cnt <= done_cnt + 1;
      end
      p_stall <= (rd || wr) && waitreq;
      p_a     <= addr;
      p_be    <= be;
      p_wd    <= wdata;
      if (p_stall && (!(rd || wr) || addr != p_a || be != p_be || wdata != p_wd))
        unstable <= unstable + 1;
    end
  end
endmodule

module bus_width_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int SAW = AW - 1;
  localparam int NW  = 2 ** (AW - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [AW-1:0] ma   [2];
  logic [3:0]    mbe  [2];
  logic          mrd  [2];
  logic          mwr  [2];
  logic [31:0]   mwd  [2];
  logic [31:0]   mrdat[2];
  logic          mwait[2];
  logic [SAW-1:0] sa  [2];
  logic [1:0]     sbe [2];
  logic           srd [2];
  logic           swr [2];
  logic [15:0]    swd [2];
  logic [15:0]    srdat[2];
  logic           swait[2];
  logic [3:0]     stall[2];

  bus_width_adapter #(.AW(AW), .SPLIT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .m_address(ma[0]), .m_byteenable(mbe[0]),
    .m_read(mrd[0]), .m_write(mwr[0]), .m_writedata(mwd[0]),
    .m_readdata(mrdat[0]), .m_waitrequest(mwait[0]),
    .s_address(sa[0]), .s_byteenable(sbe[0]), .s_read(srd[0]), .s_write(swr[0]),
    .s_writedata(swd[0]), .s_readdata(srdat[0]), .s_waitrequest(swait[0]));

  bus_width_adapter #(.AW(AW), .SPLIT(1'b0)) dut_nat_i (
    .clk(clk), .rst(rst), .m_address(ma[1]), .m_byteenable(mbe[1]),
    .m_read(mrd[1]), .m_write(mwr[1]), .m_writedata(mwd[1]),
    .m_readdata(mrdat[1]), .m_waitrequest(mwait[1]),
    .s_address(sa[1]), .s_byteenable(sbe[1]), .s_read(srd[1]), .s_write(swr[1]),
    .s_writedata(swd[1]), .s_readdata(srdat[1]), .s_waitrequest(swait[1]));

  wadp_tb_slave #(.SAW(SAW)) slv0 (.clk(clk), .rst(rst), .stall_len(stall[0]),
    .addr(sa[0]), .be(sbe[0]), .rd(srd[0]), .wr(swr[0]), .wdata(swd[0]),
    .rdata(srdat[0]), .waitreq(swait[0]));
  wadp_tb_slave #(.SAW(SAW)) slv1 (.clk(clk), .rst(rst), .stall_len(stall[1]),
    .addr(sa[1]), .be(sbe[1]), .rd(srd[1]), .wr(swr[1]), .wdata(swd[1]),
    .rdata(srdat[1]), .waitreq(swait[1]));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [7:0]  shb [4*NW];
  logic [15:0] shn [NW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w, input int pass);
    return (32'h9E3779B9 * 32'(w + 1)) ^ (32'(pass) << 28) ^ 32'h00A5_5A00;
  endfunction

  task automatic xfer(input int idx, input bit wr, input int w, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    ma[idx]  = AW'(w * 4);
    mbe[idx] = be;
    mwd[idx] = wd;
    mwr[idx] = wr;
    mrd[idx] = !wr;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (mwait[idx] && lat < 100);
    if (lat >= 100) chk(1'b0, "R8 access never ended", 32'(lat), 32'd0);
    rd = mrdat[idx];
    mwr[idx] = 1'b0;
    mrd[idx] = 1'b0;
    @(negedge clk);
    chk(mwait[idx] == 1'b1, "R8 wait low for one cycle only", 32'(mwait[idx]), 32'd1);
  endtask

  task automatic split_write(input int w, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] r;
    int lat;
    int c0;
    c0 = slv0.done_cnt;
    xfer(0, 1'b1, w, be, wd, r, lat);
    chk(slv0.done_cnt - c0 == 2, "R2 two transfers", 32'(slv0.done_cnt - c0), 32'd2);
    chk(slv0.log_a[c0 % 4] == SAW'(2 * w), "R2 first address", 32'(slv0.log_a[c0 % 4]), 32'(2 * w));
    chk(slv0.log_a[(c0 + 1) % 4] == SAW'(2 * w + 1), "R2 second address",
        32'(slv0.log_a[(c0 + 1) % 4]), 32'(2 * w + 1));
    chk(slv0.log_be[c0 % 4] == be[1:0], "R3 low enables", 32'(slv0.log_be[c0 % 4]), 32'(be[1:0]));
    chk(slv0.log_be[(c0 + 1) % 4] == be[3:2], "R3 high enables (also when 00)",
        32'(slv0.log_be[(c0 + 1) % 4]), 32'(be[3:2]));
    chk(slv0.log_wd[c0 % 4] == wd[15:0], "R4 low data", 32'(slv0.log_wd[c0 % 4]), 32'(wd[15:0]));
    chk(slv0.log_wd[(c0 + 1) % 4] == wd[31:16], "R4 high data",
        32'(slv0.log_wd[(c0 + 1) % 4]), 32'(wd[31:16]));
    for (int b = 0; b < 4; b++) if (be[b]) shb[4 * w + b] = wd[8 * b +: 8];
  endtask

  task automatic split_read(input int w, input int exp_lat);
    logic [31:0] r;
    logic [31:0] e;
    int lat;
    xfer(0, 1'b0, w, 4'hF, 32'd0, r, lat);
    e = {shb[4 * w + 3], shb[4 * w + 2], shb[4 * w + 1], shb[4 * w]};
    chk(r === e, "R5 assembled read", r, e);
    if (exp_lat > 0) chk(lat == exp_lat, "R8 split latency", 32'(lat), 32'(exp_lat));
  endtask

  task automatic trunc_write(input int w, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] r;
    int lat;
    int c0;
    c0 = slv1.done_cnt;
    xfer(1, 1'b1, w, be, wd, r, lat);
    chk(slv1.done_cnt - c0 == 1, "R6 one transfer", 32'(slv1.done_cnt - c0), 32'd1);
    chk(slv1.log_a[c0 % 4] == SAW'(w), "R6 word index address", 32'(slv1.log_a[c0 % 4]), 32'(w));
    chk(slv1.log_be[c0 % 4] == be[1:0], "R6 enables", 32'(slv1.log_be[c0 % 4]), 32'(be[1:0]));
    chk(slv1.log_wd[c0 % 4] == wd[15:0], "R7 low data only", 32'(slv1.log_wd[c0 % 4]), 32'(wd[15:0]));
    if (be[0]) shn[w][7:0]  = wd[7:0];
    if (be[1]) shn[w][15:8] = wd[15:8];
  endtask

  task automatic trunc_read(input int w, input int exp_lat);
    logic [31:0] r;
    int lat;
    xfer(1, 1'b0, w, 4'hF, 32'd0, r, lat);
    chk(r === {16'h0000, shn[w]}, "R7 zero upper read", r, {16'h0000, shn[w]});
    if (exp_lat > 0) chk(lat == exp_lat, "R8 truncating latency", 32'(lat), 32'(exp_lat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      ma[i] = '0; mbe[i] = '0; mrd[i] = 1'b0; mwr[i] = 1'b0; mwd[i] = '0; stall[i] = '0;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk(!srd[i] && !swr[i], "R1 strobes low after reset", {30'd0, srd[i], swr[i]}, 32'd0);
      chk(mwait[i] == 1'b1, "R1 wait high after reset", 32'(mwait[i]), 32'd1);
    end

    // Fill, then sweep all 16 enable patterns, then read back (no stall).
    for (int w = 0; w < NW; w++) split_write(w, 4'hF, pat(w, 1));
    for (int w = 0; w < NW; w++) split_write(w, 4'(w), pat(w, 2));
    for (int w = 0; w < NW; w++) split_read(w, 3);
    for (int w = 0; w < NW; w++) trunc_write(w, 4'hF, pat(w, 1));
    for (int w = 0; w < NW; w++) trunc_write(w, 4'(w), pat(w, 2));
    for (int w = 0; w < NW; w++) trunc_read(w, 2);

    // R9: stalled slaves, checked for latency, hold and data.
    for (int s = 1; s <= 4; s++) begin
      stall[0] = 4'(s);
      stall[1] = 4'(s);
      split_write(s, 4'b0110, pat(s, 3));
      split_read(s, 2 * s + 3);
      trunc_write(s + 8, 4'b0001, pat(s, 4));
      trunc_read(s + 8, s + 2);
    end
    chk(slv0.unstable == 0, "R9 split outputs held while stalled", 32'(slv0.unstable), 32'd0);
    chk(slv1.unstable == 0, "R9 truncating outputs held while stalled", 32'(slv1.unstable), 32'd0);

    // R10: reset while a stalled split read is in its first phase.
    stall[0] = 4'd9;
    @(negedge clk);
    ma[0] = AW'(20); mbe[0] = 4'hF; mrd[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk(srd[0] == 1'b1, "R10 read in flight before reset", 32'(srd[0]), 32'd1);
    rst = 1'b1;
    mrd[0] = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(!srd[0] && !swr[0], "R10 strobes dropped by reset", {30'd0, srd[0], swr[0]}, 32'd0);
    chk(mwait[0] == 1'b1, "R10 wait high after reset", 32'(mwait[0]), 32'd1);
    stall[0] = 4'd0;
    split_read(5, 3);
    split_write(6, 4'b1100, pat(6, 5));
    split_read(6, 3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule